// File: doc/BRIEF.md
# LPC Firmware Window Address Translator

This block sits between an LPC firmware-cycle decoder and an AHB master. It takes a 32-bit firmware address and decides whether the address falls inside one programmable window. If it does, the block turns it into a 32-bit AHB address. Only the upper half of the address takes part in either step. The lower half passes straight through, so a window always covers whole 64 KiB pages.

The window is set by two 32-bit configuration registers. Each register packs two 16-bit fields.
- The window register holds a remap base and a match base.
- The mask register holds a remap mask and a don't-care mask.

The match is bit by bit: upper address bits whose don't-care bit is set are ignored, and every other bit must equal the match base. The remap is also bit by bit: each upper AHB bit is taken from the remap base where the remap mask is set, and from the incoming address where it is clear.

The translated address is available combinationally at all times. When a lookup is presented with a valid strobe, the block answers one cycle later.
- On a hit it raises a hit strobe together with the registered AHB address.
- On a miss it raises a miss flag instead and makes no AHB request, so the LPC side can close the cycle with no response.

Top module: `lpcwin_xlate`

## Requirements
- R1: After reset both configuration registers read back 0x00000000, and the hit strobe and miss flag are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next rising edge into the register picked by `cfg_sel`: 0 selects the window register, 1 the mask register. `cfg_rdata` shows the register picked by `cfg_sel` without delay. A lookup in the same cycle as a write still uses the old contents.
- R3: Field layout: the window register holds the remap base in [31:16] and the match base in [15:0]. The mask register holds the remap mask in [31:16] and the don't-care mask in [15:0].
- R4: A lookup hits when every upper address bit [31:16] whose don't-care bit is 0 equals the matching match-base bit. Bits whose don't-care bit is 1 have no effect on the result.
- R5: Each AHB address bit [31:16] equals the remap-base bit where the remap-mask bit is 1, and the LPC address bit where it is 0.
- R6: AHB address bits [15:0] always equal LPC address bits [15:0].
- R7: One cycle after a cycle with `lpc_valid` high, exactly one of `ahb_hit` and `lpc_miss` is high for one cycle. When `lpc_valid` was low, both are low.
- R8: `ahb_addr` is the registered translation of the address that produced the hit and is valid while `ahb_hit` is high. A miss never raises `ahb_hit`.
- R9: With window 0x3000FCE0 and mask 0xFFE0001F, LPC 0xFCE00000..0xFCFFFFFF maps to AHB 0x30000000..0x301FFFFF, and addresses just outside that range miss.
- R10: With window 0x30000E00 and mask 0xFE0001FF, LPC 0x0E000000..0x0FFFFFFF maps to AHB 0x30000000..0x31FFFFFF, and addresses just outside that range miss.
- R11: With reset configuration, only addresses whose upper half is 0x0000 hit, and they translate to themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Register select: 0 window, 1 mask |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected register contents |
| lpc_valid | input | 1 | Lookup strobe |
| lpc_addr | input | 32 | LPC firmware-cycle address |
| xlat_addr | output | 32 | Combinational translation of `lpc_addr` |
| ahb_hit | output | 1 | Registered hit strobe (AHB request) |
| ahb_addr | output | 32 | Registered translated address, valid with `ahb_hit` |
| lpc_miss | output | 1 | Registered miss flag |

## Verification
The assertions check on every cycle that a valid lookup gets exactly one response and that a response never appears without one. They also check that the low half passes through, that a hit agrees with the per-bit match rule against the configuration of the previous cycle, and that the registers hold steady when no write occurs. The exact remapped upper half, the two window examples, and the edges of each range are shown only by the bench. It checks them against a reference model, using directed boundary addresses and random windows and addresses.

// File: rtl/lpcwin_pkg.sv
package lpcwin_pkg;
    typedef enum logic {
        SEL_WIN = 1'b0,
        SEL_MSK = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/lpcwin_cfg.sv
module lpcwin_cfg
    import lpcwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] win_q,
    output logic [ADDR_W-1:0] msk_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] win;
        logic [ADDR_W-1:0] msk;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (sel == SEL_MSK) st_d.msk = wdata;
            else                st_d.win = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_q = st_q.win;
    assign msk_q = st_q.msk;
    assign rdata = (sel == SEL_MSK) ? st_q.msk : st_q.win;
endmodule

// File: rtl/lpcwin_match.sv
module lpcwin_match #(
    parameter int HI_W = 16
) (
    input  logic [HI_W-1:0] up_addr,
    input  logic [HI_W-1:0] base,
    input  logic [HI_W-1:0] ignore,
    output logic            hit
);
    logic [HI_W-1:0] bit_ok;

    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        assign bit_ok[i] = ignore[i] | ~(up_addr[i] ^ base[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/lpcwin_remap.sv
module lpcwin_remap #(
    parameter int HI_W = 16
) (
    input  logic [HI_W-1:0] up_addr,
    input  logic [HI_W-1:0] base,
    input  logic [HI_W-1:0] take_base,
    output logic [HI_W-1:0] up_out
);
    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        assign up_out[i] = take_base[i] ? base[i] : up_addr[i];
    end
endmodule

// File: rtl/lpcwin_xlate.sv
module lpcwin_xlate
    import lpcwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              lpc_valid,
    input  logic [ADDR_W-1:0] lpc_addr,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              ahb_hit,
    output logic [ADDR_W-1:0] ahb_addr,
    output logic              lpc_miss
);
    localparam int HI_W = ADDR_W / 2;
    localparam int LO_W = ADDR_W - HI_W;

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [ADDR_W-1:0] addr;
    } resp_t;

    logic [ADDR_W-1:0] cfg_win_q, cfg_msk_q;
    logic [HI_W-1:0]   remap_base, match_base, remap_mask, dc_mask;
    logic [HI_W-1:0]   up_out;
    logic              win_hit;
    resp_t             rs_d, rs_q;

    lpcwin_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .win_q (cfg_win_q),
        .msk_q (cfg_msk_q)
    );

    assign remap_base = cfg_win_q[ADDR_W-1:LO_W];
    assign match_base = cfg_win_q[HI_W-1:0];
    assign remap_mask = cfg_msk_q[ADDR_W-1:LO_W];
    assign dc_mask    = cfg_msk_q[HI_W-1:0];

    lpcwin_match #(.HI_W(HI_W)) u_match (
        .up_addr (lpc_addr[ADDR_W-1:LO_W]),
        .base    (match_base),
        .ignore  (dc_mask),
        .hit     (win_hit)
    );

    lpcwin_remap #(.HI_W(HI_W)) u_remap (
        .up_addr   (lpc_addr[ADDR_W-1:LO_W]),
        .base      (remap_base),
        .take_base (remap_mask),
        .up_out    (up_out)
    );

    assign xlat_addr = {up_out, lpc_addr[LO_W-1:0]};

    always_comb begin
        rs_d      = rs_q;
        rs_d.hit  = lpc_valid & win_hit;
        rs_d.miss = lpc_valid & ~win_hit;
        if (lpc_valid && win_hit) rs_d.addr = xlat_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ahb_hit  = rs_q.hit;
    assign lpc_miss = rs_q.miss;
    assign ahb_addr = rs_q.addr;
endmodule

// File: rtl/lpcwin_xlate_chk.sv
module lpcwin_xlate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              lpc_valid,
    input logic [ADDR_W-1:0] lpc_addr,
    input logic              ahb_hit,
    input logic [ADDR_W-1:0] ahb_addr,
    input logic              lpc_miss,
    input logic [ADDR_W-1:0] win_q,
    input logic [ADDR_W-1:0] msk_q
);
    localparam int HI_W = ADDR_W / 2;

    // R7: a valid lookup is answered next cycle
    a_r7_answered: assert property (@(posedge clk) disable iff (!rst_n)
        lpc_valid |=> (ahb_hit || lpc_miss));

    // R7: never both flags at once
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ahb_hit && lpc_miss));

    // R7: no response without a lookup
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_hit || lpc_miss) |-> $past(lpc_valid));

    // R6: low half passes through on a hit
    a_r6_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_hit |-> (ahb_addr[HI_W-1:0] == $past(lpc_addr[HI_W-1:0])));

    // R4: a hit agrees with the masked compare of the previous cycle
    a_r4_match_rule: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_hit |-> ((($past(lpc_addr[ADDR_W-1:HI_W]) ^ $past(win_q[HI_W-1:0]))
                      & ~$past(msk_q[HI_W-1:0])) == '0));

    // R2: registers keep their value without a write
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(win_q) && $stable(msk_q)));

    // R2: read port follows the select
    a_r2_readsel: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata == (cfg_sel ? msk_q : win_q));
endmodule

bind lpcwin_xlate lpcwin_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata),
    .lpc_valid (lpc_valid),
    .lpc_addr  (lpc_addr),
    .ahb_hit   (ahb_hit),
    .ahb_addr  (ahb_addr),
    .lpc_miss  (lpc_miss),
    .win_q     (cfg_win_q),
    .msk_q     (cfg_msk_q)
);

// File: tb/tb_lpcwin_xlate.sv
module tb_lpcwin_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lpc_valid = 1'b0;
    logic [31:0] lpc_addr = '0;
    logic [31:0] xlat_addr;
    logic        ahb_hit;
    logic [31:0] ahb_addr;
    logic        lpc_miss;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] m_win = '0, m_msk = '0;

    always #2.5 clk = ~clk;

    lpcwin_xlate dut (.*);

    function automatic logic ref_hit(logic [31:0] w, logic [31:0] m, logic [31:0] a);
        return (((a[31:16] ^ w[15:0]) & ~m[15:0]) == 16'h0);
    endfunction

    function automatic logic [31:0] ref_addr(logic [31:0] w, logic [31:0] m, logic [31:0] a);
        return {(w[31:16] & m[31:16]) | (a[31:16] & ~m[31:16]), a[15:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_msk = d; else m_win = d;
    endtask

    task automatic lookup(string req, logic [31:0] a);
        logic eh;
        logic [31:0] ea;
        @(negedge clk);
        lpc_valid = 1'b1; lpc_addr = a;
        eh = ref_hit(m_win, m_msk, a);
        ea = ref_addr(m_win, m_msk, a);
        #1;
        check({req, " xlat"}, xlat_addr, ea);
        @(negedge clk);
        lpc_valid = 1'b0;
        check({req, " hit"}, {31'b0, ahb_hit}, {31'b0, eh});
        check({req, " miss"}, {31'b0, lpc_miss}, {31'b0, ~eh});
        if (eh) check({req, " ahb_addr"}, ahb_addr, ea);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cfg_sel = 1'b0; #1;
        check("R1 win reg", cfg_rdata, 32'h0);
        cfg_sel = 1'b1; #1;
        check("R1 msk reg", cfg_rdata, 32'h0);
        check("R1 flags", {30'b0, ahb_hit, lpc_miss}, 32'h0);

        // R11 reset configuration
        lookup("R11 zero page", 32'h0000_BEEF);
        lookup("R11 other page", 32'h0001_0000);
        lookup("R11 top page", 32'hFFFF_FFFF);

        // R7 idle: no strobe, no response
        @(negedge clk);
        lpc_addr = 32'h0000_0000;
        @(negedge clk);
        check("R7 idle", {30'b0, ahb_hit, lpc_miss}, 32'h0);

        // R2 R3 write/readback
        cfg_write(1'b0, 32'h3000_FCE0);
        cfg_write(1'b1, 32'hFFE0_001F);
        cfg_sel = 1'b0; #1;
        check("R2 win readback", cfg_rdata, 32'h3000_FCE0);
        cfg_sel = 1'b1; #1;
        check("R2 msk readback", cfg_rdata, 32'hFFE0_001F);

        // R9 first window example
        lookup("R9 low edge", 32'hFCE0_0000);
        check("R9 low edge target", ahb_addr, 32'h3000_0000);
        lookup("R9 high edge", 32'hFCFF_FFFF);
        check("R9 high edge target", ahb_addr, 32'h301F_FFFF);
        lookup("R9 below", 32'hFCDF_FFFF);
        lookup("R9 above", 32'hFD00_0000);

        // R2 lookup in the write cycle uses old config
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h3000_0E00;
        lpc_valid = 1'b1; lpc_addr = 32'h0E00_0000;
        @(negedge clk);
        cfg_we = 1'b0; lpc_valid = 1'b0;
        check("R2 old config used", {31'b0, lpc_miss}, 32'h1);
        m_win = 32'h3000_0E00;

        // R10 second window example
        cfg_write(1'b1, 32'hFE00_01FF);
        lookup("R10 low edge", 32'h0E00_0000);
        check("R10 low edge target", ahb_addr, 32'h3000_0000);
        lookup("R10 high edge", 32'h0FFF_FFFF);
        check("R10 high edge target", ahb_addr, 32'h31FF_FFFF);
        lookup("R10 below", 32'h0DFF_FFFF);
        lookup("R10 above", 32'h1000_0000);
        // R8 address holds after a miss
        check("R8 addr held after miss", ahb_addr, 32'h31FF_FFFF);

        // R4 R5 R6 random windows and addresses
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            if (i % 40 == 0) begin
                cfg_write(1'b0, $urandom);
                cfg_write(1'b1, $urandom);
            end
            a = $urandom;
            if ($urandom % 2) begin
                logic [15:0] r;
                r = 16'($urandom);
                a[31:16] = (m_win[15:0] & ~m_msk[15:0]) | (r & m_msk[15:0]);
            end
            lookup("R4 R5 R6 random", a);
        end

        // R4 don't-care bits ignored: all-ignore mask always hits
        cfg_write(1'b1, 32'h0000_FFFF);
        lookup("R4 all ignored", 32'hA5A5_1234);
        // R5 full remap mask replaces the upper half
        cfg_write(1'b0, 32'hCAFE_0000);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        lookup("R5 full remap", 32'h1357_9BDF);
        check("R5 full remap target", ahb_addr, 32'hCAFE_9BDF);

        finish_run();
    end
endmodule